// File: doc/BRIEF.md
# First/Next Uncorrectable Error Status Register

This block is a global error status register. It records which error source raised the first uncorrectable error and which sources raised uncorrectable errors after it. There are three sources: a serial link, a set of parallel buses, and the core SRAM arrays. Each source delivers single-cycle error pulses, and each pulse is tagged as correctable or uncorrectable. Every parallel bus feeds the same bus bit, and every SRAM unit feeds the same core bit.

The status is split into a "first error" group and a "next errors" group. Each group has one bit per source. While the first group is empty, an uncorrectable error lands in the first group. Once the first group holds a bit, later errors land in the next group. All bits are sticky, and software clears them by writing 1 to them through a 32-bit register port. The read data is a continuous view of the register.

Top module: `err_first_next_status`

## Requirements
- R1: After a synchronous reset, all 32 bits of `csr_rd_data` read zero.
- R2: An error pulse whose uncorrectable tag is 0 changes no status bit.
- R3: While bits [2:0] are all zero, a single uncorrectable error sets the first-group bit of its source. Bits [5:3] stay unchanged. The new state reads back on the cycle after the pulse.
- R4: While any bit in [2:0] is set, an uncorrectable error sets the next-group bit of its source and leaves [2:0] unchanged.
- R5: When several sources report uncorrectable errors in the same cycle while [2:0] is zero, one source takes the first-group bit by fixed priority: serial link first, then parallel bus, then core. Each of the other reporting sources sets its next-group bit.
- R6: An uncorrectable error on any of the parallel buses maps to the single bus bit of the group that takes it.
- R7: An uncorrectable error from any core SRAM unit maps to the single core bit of the group that takes it.
- R8: A write with a 1 in a bit of [5:0] clears that bit. A 0 in a bit of [5:0] leaves that bit unchanged.
- R9: When a clear and a new error hit the same bit in the same cycle, the bit ends up set. Group selection uses the state held before that cycle.
- R10: The register layout is: bit 0 link first, bit 1 bus first, bit 2 core first, bit 3 link next, bit 4 bus next, bit 5 core next. Bits [31:6] always read zero.
- R11: A set bit stays set through any cycles that contain no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| link_err_valid | input | 1 | Serial link error pulse |
| link_err_uncorr | input | 1 | Serial link error is uncorrectable |
| bus_err_valid | input | NUM_BUS | Per-bus error pulses |
| bus_err_uncorr | input | NUM_BUS | Per-bus uncorrectable tags |
| core_err_valid | input | NUM_CORE | Per-SRAM-unit error pulses |
| core_err_uncorr | input | NUM_CORE | Per-SRAM-unit uncorrectable tags |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_data | input | DATA_W | Write data, 1 clears the bit |
| csr_rd_data | output | DATA_W | Register read view |

## Verification
The register state is the output, so a wrong bit appears in `csr_rd_data` on the cycle right after the edge that caused it. The bench therefore compares the whole read value against a behavioural model on every clock. The weak points are group selection, priority between sources that report together, and how a clear interacts with a new error in the same cycle. Random traffic with frequent clears reaches these cases many times, because each clear empties the first group again.

// File: rtl/err_first_next_status.sv
module err_first_next_status #(
  parameter int NUM_BUS  = 2,
  parameter int NUM_CORE = 4,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                link_err_valid,
  input  logic                link_err_uncorr,
  input  logic [NUM_BUS-1:0]  bus_err_valid,
  input  logic [NUM_BUS-1:0]  bus_err_uncorr,
  input  logic [NUM_CORE-1:0] core_err_valid,
  input  logic [NUM_CORE-1:0] core_err_uncorr,
  input  logic                csr_wr_en,
  input  logic [DATA_W-1:0]   csr_wr_data,
  output logic [DATA_W-1:0]   csr_rd_data
);
  localparam int SRC = 3;

  logic [SRC-1:0] first_q, next_q;
  logic [SRC-1:0] unc, pick, spill, clr_first, clr_next;
  logic           first_empty;

  // source order: 0 link, 1 bus, 2 core
  assign unc = {|(core_err_valid & core_err_uncorr),
                |(bus_err_valid & bus_err_uncorr),
                link_err_valid & link_err_uncorr};

  assign first_empty = (first_q == '0);
  assign pick        = first_empty ? (unc & (~unc + 1'b1)) : '0;
  assign spill       = unc & ~pick;
  assign clr_first   = csr_wr_en ? csr_wr_data[SRC-1:0]     : '0;
  assign clr_next    = csr_wr_en ? csr_wr_data[2*SRC-1:SRC] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      next_q  <= '0;
    end else begin
      first_q <= (first_q & ~clr_first) | pick;
      next_q  <= (next_q  & ~clr_next)  | spill;
    end
  end

  assign csr_rd_data = {{(DATA_W-2*SRC){1'b0}}, next_q, first_q};

  assert_first_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(first_q));

  assert_corr_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (!csr_wr_en && unc == '0) |=> ($stable(first_q) && $stable(next_q)));

  assert_empty_fills_R3: assert property (@(posedge clk) disable iff (rst)
    (first_q == '0 && unc != '0) |=> (first_q != '0));

  assert_link_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (first_q == '0 && unc[0] && !csr_wr_en) |=> (first_q == 3'b001));

  assert_held_first_R4: assert property (@(posedge clk) disable iff (rst)
    (first_q != '0 && !csr_wr_en) |=> $stable(first_q));

  assert_sticky_first_R11: assert property (@(posedge clk) disable iff (rst)
    (first_q != '0 && !csr_wr_en) |=> (first_q != '0));

  for (genvar i = 0; i < SRC; i++) begin : g_next_chk
    assert_next_set_R4: assert property (@(posedge clk) disable iff (rst)
      (first_q != '0 && unc[i]) |=> next_q[i]);
    assert_sticky_next_R11: assert property (@(posedge clk) disable iff (rst)
      (next_q[i] && !csr_wr_en) |=> next_q[i]);
  end
endmodule

// File: tb/err_first_next_status_tb.sv
module err_first_next_status_tb;
  localparam int NB = 2;
  localparam int NC = 4;

  logic clk = 0, rst = 1;
  logic link_v = 0, link_u = 0;
  logic [NB-1:0] bus_v = '0, bus_u = '0;
  logic [NC-1:0] core_v = '0, core_u = '0;
  logic wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd;

  int tests = 0, fails = 0;
  int m_first = 0, m_next = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  err_first_next_status #(.NUM_BUS(NB), .NUM_CORE(NC), .DATA_W(32)) u_dut (
    .clk(clk), .rst(rst),
    .link_err_valid(link_v), .link_err_uncorr(link_u),
    .bus_err_valid(bus_v), .bus_err_uncorr(bus_u),
    .core_err_valid(core_v), .core_err_uncorr(core_u),
    .csr_wr_en(wr_en), .csr_wr_data(wr_data), .csr_rd_data(rd));

  function automatic int expected();
    return (m_next << 3) | m_first;
  endfunction

  task automatic check(string req, int exp_val);
    tests++;
    if (rd !== 32'(exp_val)) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, rd, 32'(exp_val));
    end
  endtask

  // behavioural model step for the inputs currently driven
  task automatic model_step();
    int srcs[$];
    int clrmask;
    srcs = {};
    if (link_v && link_u) srcs.push_back(0);
    if ((bus_v & bus_u) != 0) srcs.push_back(1);
    if ((core_v & core_u) != 0) srcs.push_back(2);
    clrmask = wr_en ? int'(wr_data[5:0]) : 0;
    if (m_first == 0 && srcs.size() > 0) begin
      int winner = srcs.pop_front();
      m_first = 1 << winner;
    end else begin
      m_first = m_first & ~(clrmask & 7);
    end
    m_next = m_next & ~((clrmask >> 3) & 7);
    foreach (srcs[k]) m_next = m_next | (1 << srcs[k]);
  endtask

  // apply one cycle: drive at negedge, model, compare at next negedge
  task automatic cyc(string req, bit lv, bit lu, logic [NB-1:0] bv, logic [NB-1:0] bu,
                     logic [NC-1:0] cv, logic [NC-1:0] cu, bit we, logic [31:0] wd);
    link_v = lv; link_u = lu; bus_v = bv; bus_u = bu;
    core_v = cv; core_u = cu; wr_en = we; wr_data = wd;
    model_step();
    @(negedge clk);
    check(req, expected());
  endtask

  task automatic idle(string req);
    cyc(req, 0, 0, '0, '0, '0, '0, 0, '0);
  endtask

  task automatic clear_all();
    cyc("R8", 0, 0, '0, '0, '0, '0, 1, 32'h3F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1", 0);
    // R2: correctable pulses everywhere
    cyc("R2", 1, 0, '1, '0, '1, '0, 0, '0);
    // R3: single core error fills first group, R7 any unit
    cyc("R3 R7", 0, 0, '0, '0, 4'b1000, 4'b1000, 0, '0);
    check("R10", 32'h4);
    // R4: later bus error goes to next; R6 upper bus
    cyc("R4 R6", 0, 0, 2'b10, 2'b10, '0, '0, 0, '0);
    // R11: sticky over idle
    idle("R11"); idle("R11");
    // R8: write zero no effect, then partial clear
    cyc("R8", 0, 0, '0, '0, '0, '0, 1, 32'h0);
    cyc("R8", 0, 0, '0, '0, '0, '0, 1, 32'h4);
    check("R10", 32'h10);
    clear_all();
    // R5: all three together
    cyc("R5", 1, 1, 2'b01, 2'b01, 4'b0001, 4'b0001, 0, '0);
    check("R10", 32'h31);
    clear_all();
    // R5: bus and core together
    cyc("R5", 0, 0, 2'b01, 2'b01, 4'b0100, 4'b0100, 0, '0);
    check("R5", 32'h22);
    // R9: clear next-core while core errors again
    cyc("R9", 0, 0, '0, '0, 4'b0010, 4'b0010, 1, 32'h20);
    check("R9", 32'h22);
    // R9: clear first while link errors: goes to next since first was full
    cyc("R9", 1, 1, '0, '0, '0, '0, 1, 32'h02);
    check("R9", 32'h28);
    // R10: upper write bits ignored, upper reads zero
    cyc("R10", 0, 0, '0, '0, '0, '0, 1, 32'hFFFF_FFC0);
    clear_all();
    check("R1", 0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit lv = ($urandom_range(0, 5) == 0);
      bit we = ($urandom_range(0, 7) == 0);
      cyc("R2 R3 R4 R5 R8 R9 R11", lv, 1'($urandom), NB'($urandom) & NB'($urandom),
          NB'($urandom), NC'($urandom) & NC'($urandom) & NC'($urandom), NC'($urandom),
          we, $urandom);
    end
    done = 1;
  end

  initial begin
    int cnt = 0;
    while (!done && cnt < 20000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule